// File: doc/BRIEF.md
# ODT Power-Down Exit Mode Tracker

This block follows a DDR3-class device through precharge power-down and its exit, cycle by cycle. For every clock it reports whether the device answers an ODT pin change asynchronously, through an uncertain transition period, or synchronously. It also reports whether the device has not entered power-down since reset. For every ODT edge it reports the earliest and latest clock, counted from the edge cycle, at which termination may change. A memory controller or a protocol monitor can use it to judge whether an observed or planned termination change is legal.

The uncertain period starts WL−1 cycles before the cycle that first samples CKE high. That cycle is only known after the fact, so each cycle's label is held in a delay line of MAX_WL−1 stages. When the exit is seen, the cycles already in the line are rewritten. Labels therefore leave the block after a fixed delay.

Whether the DLL is frozen during power-down is latched when CKE first drops. The write latency and the exit-window length in clocks are configuration inputs. They are held steady while an episode is in progress. The analog bounds are supplied as parameters that have already been rounded to whole clocks.

Top module: `odt_pdx_tracker`

## Requirements
- R1: After reset, and until CKE is first sampled low, mode_o reads 2'b11 (not in power-down) and edge_vld_o is 0.
- R2: The label of the cycle sampled at clock edge t appears on mode_o, edge_vld_o, edge_rise_o, early_o and late_o right after clock edge t+MAX_WL−1. This delay is the same for every cycle.
- R3: With dll_on_i at 0 when CKE first drops, every CKE-low cycle of the episode is labelled 2'b00 (asynchronous) unless R4 applies to it.
- R4: Let c be the cycle in which CKE is sampled high after power-down. The cycles c−(WL−1) through c−1 that are power-down cycles, and the cycles c through c+txpdll_i−1, are labelled 2'b01 (transition). This holds only while the DLL is frozen.
- R5: Once the exit window has elapsed, cycles are labelled 2'b10 (synchronous) until CKE is sampled low again.
- R6: With dll_on_i at 1 when CKE first drops, every cycle of that episode, in power-down and after it, is labelled 2'b10.
- R7: If CKE is sampled low inside the exit window, the tracker returns to power-down. The next CKE-high cycle starts a new window of the full txpdll_i length and a new backward window of WL−1 cycles.
- R8: edge_vld_o is 1 exactly in the output cycles whose ODT level differs from the previous cycle's level. The value before the first cycle after reset is taken as 0. edge_rise_o gives the new level.
- R9: For an edge in a 2'b10 cycle, with ODTL = WL−2: a rise is bounded by [ODTL+AON_MIN_CK, ODTL+AON_MAX_CK] and a fall by [ODTL+AOF_MIN_CK, ODTL+AOF_MAX_CK].
- R10: For an edge in a 2'b00 cycle: a rise is bounded by [AONPD_MIN_CK, AONPD_MAX_CK] and a fall by [AOFPD_MIN_CK, AOFPD_MAX_CK].
- R11: For an edge in a 2'b01 cycle, early_o is the smaller of the asynchronous and synchronous minimums. late_o is the larger of the two maximums.
- R12: An edge in a 2'b11 cycle carries the synchronous bounds of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Registered CKE level for this cycle |
| odt_i | input | 1 | ODT pin level for this cycle |
| dll_on_i | input | 1 | 1: DLL stays on in power-down, 0: DLL frozen |
| wl_i | input | WL_W | Write latency in clocks (2..MAX_WL) |
| txpdll_i | input | TXW | Exit window length in clocks (at least 1) |
| mode_o | output | 2 | Label of the delayed cycle: 00 async, 01 transition, 10 sync, 11 not in power-down |
| edge_vld_o | output | 1 | ODT changed in the delayed cycle |
| edge_rise_o | output | 1 | New ODT level of that edge |
| early_o | output | BW | Earliest termination change, in clocks after the edge cycle |
| late_o | output | BW | Latest termination change, in clocks after the edge cycle |

## Verification
Every result of this block is due MAX_WL−1 clocks after the edge that sampled its cycle. This covers the mode label, the edge flag and direction, and both bounds. The bench computes the whole expected label sequence for a scenario before driving it. It does this with a forward pass over CKE followed by a backward sweep from each exit cycle. Inputs for cycle k are driven on the falling edge just before clock edge k. On that same falling edge the outputs are compared with the expectation for cycle k−MAX_WL, which makes the fixed delay part of every comparison. Directed scenarios cover the shortest and longest write latency, a one-clock exit window, an exit aborted by CKE falling again, and the DLL-on case. Seeded random CKE runs and random ODT toggles fill in the rest.

// File: rtl/odt_pdx_pkg.sv
package odt_pdx_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_TRANS = 2'b01,
    MODE_SYNC  = 2'b10,
    MODE_IDLE  = 2'b11
  } odt_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PD,
    ST_XWIN,
    ST_SYNC
  } pd_state_e;

  typedef struct packed {
    odt_mode_e mode;
    logic      odt;
  } slot_t;

  localparam slot_t SLOT_RST = '{mode: MODE_IDLE, odt: 1'b0};

endpackage

// File: rtl/odt_pdx_phase.sv
module odt_pdx_phase
  import odt_pdx_pkg::*;
#(
  parameter int unsigned TXW = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cke_i,
  input  logic           dll_on_i,
  input  logic [TXW-1:0] txpdll_i,
  output odt_mode_e      mode_o,
  output logic           exit_o
);

  pd_state_e      state_q, state_d;
  logic           frz_q, frz_d;
  logic [TXW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    frz_d   = frz_q;
    cnt_d   = cnt_q;
    exit_o  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_SYNC: begin
        if (!cke_i) begin
          state_d = ST_PD;
          frz_d   = !dll_on_i;
        end
      end
      ST_PD: begin
        if (cke_i) begin
          state_d = ST_XWIN;
          exit_o  = 1'b1;
          cnt_d   = (txpdll_i == '0) ? '0 : txpdll_i - 1'b1;
        end
      end
      ST_XWIN: begin
        if (!cke_i)           state_d = ST_PD;
        else if (cnt_q == '0) state_d = ST_SYNC;
        else                  cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // label of the current cycle follows the state it lands in
  always_comb begin
    unique case (state_d)
      ST_IDLE: mode_o = MODE_IDLE;
      ST_PD:   mode_o = frz_d ? MODE_ASYNC : MODE_SYNC;
      ST_XWIN: mode_o = frz_d ? MODE_TRANS : MODE_SYNC;
      default: mode_o = MODE_SYNC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      frz_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      frz_q   <= frz_d;
      cnt_q   <= cnt_d;
    end
  end

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && cke_i) |=> (state_q == ST_IDLE));

  assert_win_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XWIN && !cke_i) |=> (state_q == ST_PD));

  assert_win_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XWIN) |-> (txpdll_i == '0 || cnt_q < txpdll_i));

  assert_exit_only_from_pd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |=> (state_q == ST_XWIN));

endmodule

// File: rtl/odt_pdx_line.sv
module odt_pdx_line
  import odt_pdx_pkg::*;
#(
  parameter int unsigned LAT  = 16,
  parameter int unsigned WL_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  slot_t           in_i,
  input  logic            exit_i,
  input  logic [WL_W-1:0] wl_i,
  output slot_t           out_o
);

  slot_t line_q [LAT+1];
  slot_t nxt    [LAT+1];

  assign nxt[0] = in_i;

  // an exit rewrites the async cycles that fall inside the backward window
  for (genvar k = 1; k <= LAT; k++) begin : g_stage
    localparam logic [WL_W:0] K_V = (WL_W+1)'(k);
    logic hit;
    assign hit    = exit_i && (K_V < {1'b0, wl_i}) && (line_q[k-1].mode == MODE_ASYNC);
    assign nxt[k] = hit ? slot_t'{mode: MODE_TRANS, odt: line_q[k-1].odt} : line_q[k-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i <= LAT; i++) line_q[i] <= SLOT_RST;
    end else begin
      for (int i = 0; i <= LAT; i++) line_q[i] <= nxt[i];
    end
  end

  assign out_o = line_q[LAT];

  assert_relabel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_i && wl_i >= WL_W'(2) && line_q[0].mode == MODE_ASYNC)
      |=> (line_q[1].mode == MODE_TRANS));

  assert_no_relabel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exit_i && line_q[0].mode == MODE_ASYNC) |=> (line_q[1].mode == MODE_ASYNC));

endmodule

// File: rtl/odt_pdx_bounds.sv
module odt_pdx_bounds
  import odt_pdx_pkg::*;
#(
  parameter int unsigned WL_W         = 5,
  parameter int unsigned BW           = 6,
  parameter int unsigned AON_MIN_CK   = 0,
  parameter int unsigned AON_MAX_CK   = 1,
  parameter int unsigned AOF_MIN_CK   = 0,
  parameter int unsigned AOF_MAX_CK   = 1,
  parameter int unsigned AONPD_MIN_CK = 2,
  parameter int unsigned AONPD_MAX_CK = 9,
  parameter int unsigned AOFPD_MIN_CK = 2,
  parameter int unsigned AOFPD_MAX_CK = 8
) (
  input  odt_mode_e       mode_i,
  input  logic            rise_i,
  input  logic [WL_W-1:0] wl_i,
  output logic [BW-1:0]   early_o,
  output logic [BW-1:0]   late_o
);

  logic [BW-1:0] odtl, s_min, s_max, a_min, a_max;

  assign odtl  = BW'(wl_i) - BW'(2);
  assign s_min = odtl + (rise_i ? BW'(AON_MIN_CK) : BW'(AOF_MIN_CK));
  assign s_max = odtl + (rise_i ? BW'(AON_MAX_CK) : BW'(AOF_MAX_CK));
  assign a_min = rise_i ? BW'(AONPD_MIN_CK) : BW'(AOFPD_MIN_CK);
  assign a_max = rise_i ? BW'(AONPD_MAX_CK) : BW'(AOFPD_MAX_CK);

  always_comb begin
    unique case (mode_i)
      MODE_ASYNC: begin
        early_o = a_min;
        late_o  = a_max;
      end
      MODE_TRANS: begin
        early_o = (a_min < s_min) ? a_min : s_min;
        late_o  = (a_max > s_max) ? a_max : s_max;
      end
      default: begin
        early_o = s_min;
        late_o  = s_max;
      end
    endcase
  end

endmodule

// File: rtl/odt_pdx_tracker.sv
module odt_pdx_tracker
  import odt_pdx_pkg::*;
#(
  parameter int unsigned MAX_WL       = 17,
  parameter int unsigned WL_W         = $clog2(MAX_WL + 1),
  parameter int unsigned TXW          = 6,
  parameter int unsigned BW           = 6,
  parameter int unsigned AON_MIN_CK   = 0,
  parameter int unsigned AON_MAX_CK   = 1,
  parameter int unsigned AOF_MIN_CK   = 0,
  parameter int unsigned AOF_MAX_CK   = 1,
  parameter int unsigned AONPD_MIN_CK = 2,
  parameter int unsigned AONPD_MAX_CK = 9,
  parameter int unsigned AOFPD_MIN_CK = 2,
  parameter int unsigned AOFPD_MAX_CK = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cke_i,
  input  logic            odt_i,
  input  logic            dll_on_i,
  input  logic [WL_W-1:0] wl_i,
  input  logic [TXW-1:0]  txpdll_i,
  output logic [1:0]      mode_o,
  output logic            edge_vld_o,
  output logic            edge_rise_o,
  output logic [BW-1:0]   early_o,
  output logic [BW-1:0]   late_o
);

  localparam int unsigned LAT = MAX_WL - 1;

  odt_mode_e live_mode;
  logic      exit_now;
  slot_t     live_slot, out_slot;
  logic      odt_last_q;

  odt_pdx_phase #(.TXW(TXW)) i_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cke_i    (cke_i),
    .dll_on_i (dll_on_i),
    .txpdll_i (txpdll_i),
    .mode_o   (live_mode),
    .exit_o   (exit_now)
  );

  assign live_slot = '{mode: live_mode, odt: odt_i};

  odt_pdx_line #(.LAT(LAT), .WL_W(WL_W)) i_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (live_slot),
    .exit_i (exit_now),
    .wl_i   (wl_i),
    .out_o  (out_slot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) odt_last_q <= 1'b0;
    else         odt_last_q <= out_slot.odt;
  end

  assign mode_o      = out_slot.mode;
  assign edge_vld_o  = out_slot.odt != odt_last_q;
  assign edge_rise_o = out_slot.odt;

  odt_pdx_bounds #(
    .WL_W(WL_W), .BW(BW),
    .AON_MIN_CK(AON_MIN_CK), .AON_MAX_CK(AON_MAX_CK),
    .AOF_MIN_CK(AOF_MIN_CK), .AOF_MAX_CK(AOF_MAX_CK),
    .AONPD_MIN_CK(AONPD_MIN_CK), .AONPD_MAX_CK(AONPD_MAX_CK),
    .AOFPD_MIN_CK(AOFPD_MIN_CK), .AOFPD_MAX_CK(AOFPD_MAX_CK)
  ) i_bounds (
    .mode_i  (out_slot.mode),
    .rise_i  (out_slot.odt),
    .wl_i    (wl_i),
    .early_o (early_o),
    .late_o  (late_o)
  );

  logic [BW-1:0] pd_min_c, pd_max_c;
  assign pd_min_c = edge_rise_o ? BW'(AONPD_MIN_CK) : BW'(AOFPD_MIN_CK);
  assign pd_max_c = edge_rise_o ? BW'(AONPD_MAX_CK) : BW'(AOFPD_MAX_CK);

  assert_bound_order_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_vld_o |-> (early_o <= late_o));

  assert_trans_cover_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_vld_o && mode_o == 2'b01) |-> (early_o <= pd_min_c && late_o >= pd_max_c));

  assert_edge_alt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_vld_o |=> (!edge_vld_o || edge_rise_o != $past(edge_rise_o)));

endmodule

// File: tb/test_odt_pdx_tracker.sv
module test_odt_pdx_tracker;

  localparam int CLK_P  = 10;
  localparam int MAX_WL = 17;
  localparam int LAT    = MAX_WL - 1;
  localparam int NCYC   = 260;
  localparam int WD_CYC = 100000;
  localparam int ON_MIN = 0, ON_MAX = 1, OFF_MIN = 0, OFF_MAX = 1;
  localparam int ONPD_MIN = 2, ONPD_MAX = 9, OFFPD_MIN = 2, OFFPD_MAX = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cke_i = 1'b1, odt_i = 1'b0, dll_on_i = 1'b0;
  logic [4:0] wl_i = 5'd10;
  logic [5:0] txpdll_i = 6'd10;
  logic [1:0] mode_o;
  logic       edge_vld_o, edge_rise_o;
  logic [5:0] early_o, late_o;

  int tests = 0, fails = 0;
  bit cke_a [NCYC];
  bit odt_a [NCYC];
  int exp_m [NCYC];
  bit ex_a  [NCYC];

  always #(CLK_P/2) clk = ~clk;

  odt_pdx_tracker #(
    .MAX_WL(MAX_WL), .TXW(6), .BW(6),
    .AON_MIN_CK(ON_MIN), .AON_MAX_CK(ON_MAX), .AOF_MIN_CK(OFF_MIN), .AOF_MAX_CK(OFF_MAX),
    .AONPD_MIN_CK(ONPD_MIN), .AONPD_MAX_CK(ONPD_MAX),
    .AOFPD_MIN_CK(OFFPD_MIN), .AOFPD_MAX_CK(OFFPD_MAX)
  ) i_odt_pdx_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke_i), .odt_i(odt_i), .dll_on_i(dll_on_i),
    .wl_i(wl_i), .txpdll_i(txpdll_i), .mode_o(mode_o), .edge_vld_o(edge_vld_o),
    .edge_rise_o(edge_rise_o), .early_o(early_o), .late_o(late_o)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cke(int lo, int hi, bit v);
    for (int t = lo; t <= hi; t++) cke_a[t] = v;
  endtask

  task automatic set_odt(int lo, int hi, bit v);
    for (int t = lo; t <= hi; t++) odt_a[t] = v;
  endtask

  // expected labels: forward pass over CKE, then backward sweep from each exit
  task automatic build_exp(int wl, int txp, bit dll);
    int st = 0; bit frz = 0; int cnt = 0;
    for (int t = 0; t < NCYC; t++) begin
      ex_a[t] = 1'b0;
      case (st)
        0, 3: if (!cke_a[t]) begin st = 1; frz = !dll; end
        1: if (cke_a[t]) begin st = 2; cnt = txp - 1; ex_a[t] = 1'b1; end
        default: if (!cke_a[t]) st = 1; else if (cnt == 0) st = 3; else cnt--;
      endcase
      exp_m[t] = (st == 0) ? 3 : (st == 3) ? 2 : (st == 1) ? (frz ? 0 : 2) : (frz ? 1 : 2);
    end
    for (int t = 0; t < NCYC; t++)
      if (ex_a[t])
        for (int j = 1; j < wl; j++)
          if (t - j >= 0 && exp_m[t-j] == 0) exp_m[t-j] = 1;
  endtask

  function automatic void exp_bounds(int m, bit rise, int wl, output int lo, output int hi);
    int smin, smax, amin, amax;
    smin = wl - 2 + (rise ? ON_MIN : OFF_MIN);
    smax = wl - 2 + (rise ? ON_MAX : OFF_MAX);
    amin = rise ? ONPD_MIN : OFFPD_MIN;
    amax = rise ? ONPD_MAX : OFFPD_MAX;
    if (m == 0)      begin lo = amin; hi = amax; end
    else if (m == 1) begin lo = (amin < smin) ? amin : smin; hi = (amax > smax) ? amax : smax; end
    else             begin lo = smin; hi = smax; end
  endfunction

  task automatic check_cycle(int idx, int wl, bit dll, string tag);
    int em, lo, hi; bit prev, eedge; string rq, bq;
    em = exp_m[idx];
    rq = (em == 3) ? "R1" : (em == 0) ? "R3" : (em == 1) ? "R4" : (dll ? "R6" : "R5");
    chk(mode_o == 2'(em), {"R2/", rq, tag}, $sformatf("mode cycle %0d", idx), int'(mode_o), em);
    prev  = (idx == 0) ? 1'b0 : odt_a[idx-1];
    eedge = odt_a[idx] != prev;
    chk(edge_vld_o == eedge && (!eedge || edge_rise_o == odt_a[idx]), {"R8", tag},
        $sformatf("edge cycle %0d {vld,rise}", idx), int'({edge_vld_o, edge_rise_o}),
        int'({eedge, odt_a[idx]}));
    if (eedge) begin
      exp_bounds(em, odt_a[idx], wl, lo, hi);
      bq = (em == 0) ? "R10" : (em == 1) ? "R11" : (em == 2) ? "R9" : "R12";
      chk(early_o == 6'(lo), {bq, tag}, $sformatf("early cycle %0d", idx), int'(early_o), lo);
      chk(late_o == 6'(hi), {bq, tag}, $sformatf("late cycle %0d", idx), int'(late_o), hi);
    end
  endtask

  task automatic run_scn(string tag, int wl, int txp, bit dll);
    build_exp(wl, txp, dll);
    @(negedge clk);
    rst_ni = 1'b0; wl_i = 5'(wl); txpdll_i = 6'(txp); dll_on_i = dll;
    cke_i = 1'b1; odt_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(mode_o == 2'b11, "R1", "reset mode", int'(mode_o), 3);
    chk(edge_vld_o == 1'b0, "R1", "reset edge", int'(edge_vld_o), 0);
    rst_ni = 1'b1;
    cke_i = cke_a[0]; odt_i = odt_a[0];
    for (int k = 1; k <= NCYC + LAT; k++) begin
      int idx;
      @(negedge clk);
      idx = k - 1 - LAT;
      if (idx >= 0 && idx < NCYC) check_cycle(idx, wl, dll, tag);
      if (k < NCYC) begin cke_i = cke_a[k]; odt_i = odt_a[k]; end
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog run did not finish actual=%0d expected=0", WD_CYC);
    summary();
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd1234);

    // R3 R4 R5 R12: frozen DLL, edges before, inside and after the window
    set_cke(0, NCYC-1, 1); set_cke(20, 99, 0);
    set_odt(0, 9, 0); set_odt(10, 49, 1); set_odt(50, 94, 0); set_odt(95, 104, 1);
    set_odt(105, 129, 0); set_odt(130, NCYC-1, 1);
    run_scn("", 10, 10, 1'b0);

    // R7: CKE drops inside the window, window restarts on the next rise
    set_cke(0, NCYC-1, 1); set_cke(10, 39, 0); set_cke(43, 59, 0);
    set_odt(0, 40, 0); set_odt(41, 61, 1); set_odt(62, 69, 0); set_odt(70, NCYC-1, 1);
    run_scn(" (R7)", 6, 8, 1'b0);

    // R6: DLL kept on, whole episode synchronous
    set_cke(0, NCYC-1, 1); set_cke(20, 99, 0);
    set_odt(0, 49, 0); set_odt(50, 94, 1); set_odt(95, 104, 0); set_odt(105, NCYC-1, 1);
    run_scn(" (R6)", 8, 12, 1'b1);

    // R4 boundary: WL=2 gives a one-cycle backward window, one-clock exit window
    set_cke(0, NCYC-1, 1); set_cke(20, 50, 0);
    set_odt(0, 48, 0); set_odt(49, 49, 1); set_odt(50, 51, 0); set_odt(52, NCYC-1, 1);
    run_scn(" (wl2)", 2, 1, 1'b0);

    // R4 boundary: largest WL, backward window fills the whole line
    set_cke(0, NCYC-1, 1); set_cke(5, 80, 0);
    set_odt(0, 62, 0); set_odt(63, 63, 1); set_odt(64, 80, 0); set_odt(81, NCYC-1, 1);
    run_scn(" (wlmax)", 17, 24, 1'b0);

    // random CKE runs and ODT toggles
    for (int s = 0; s < 6; s++) begin
      int t; bit v; bit o;
      t = 0; v = 1'b1; o = 1'b0;
      while (t < NCYC - 60) begin
        int len;
        len = 1 + int'($urandom % 30);
        if (t + len > NCYC - 60) len = NCYC - 60 - t;
        set_cke(t, t + len - 1, v);
        t += len; v = !v;
      end
      set_cke(NCYC - 60, NCYC - 1, 1);
      for (int i = 0; i < NCYC; i++) begin
        if ($urandom % 5 == 0) o = !o;
        odt_a[i] = o;
      end
      run_scn(" (rand)", 2 + int'($urandom % 16), 1 + int'($urandom % 24), 1'($urandom % 2));
    end

    summary();
    $finish;
  end

endmodule